// File: doc/BRIEF.md
# Weighted-Average Singleton Defuzzifier

This block turns nine unsigned output-set firing strengths into one signed crisp control increment. Each output set is a symmetric singleton with a fixed centre, so the block weights every strength by a constant centre value and sums the products. It divides that weighted sum by the plain sum of the strengths. The result is a signed fixed-point number with four fractional bits.

A caller loads the nine strengths together with a one-cycle start strobe. A restoring divider inside the block then produces one quotient bit per clock. Only the magnitude is divided, and the sign is restored afterwards, so the quotient is truncated toward zero. When the strength sum is zero, the division is skipped and the result is zero. A one-cycle done strobe marks each new result. The result then holds its value until the next done strobe.

Top module: `defz_wavg`

## Requirements
- R1: Set k (k = 0..8) is carried on `strengths_i[8k+7:8k]` as an unsigned byte, and its centre is 2k−8, so set 0 weighs −8, set 4 weighs 0 and set 8 weighs +8.
- R2: For a nonzero strength sum, `result_o` equals 16·Σ(s_k·c_k)/Σ(s_k), in 9-bit two's complement with 4 fractional bits (value 16 means +1.0).
- R3: A negative quotient is truncated toward zero. For example, −10.67 gives −10, not −11.
- R4: Every published result lies in −128..+128, which is ±8.0.
- R5: When all nine strengths are zero, no division runs, and `done_o` rises one clock edge after the accepting edge with `result_o` = 0.
- R6: For a nonzero strength sum, `done_o` rises on the 21st clock edge after the accepting edge.
- R7: `done_o` is high for one cycle per accepted request, and `result_o` keeps its value in every cycle where `done_o` is low.
- R8: A start sampled while a division is running (edges 1 to 20 after the accepting edge) is ignored. It produces no extra done and does not change the running result.
- R9: A start sampled on the 21st edge, the edge that publishes the previous result, is accepted. Both results come out correct, each on its own done pulse.
- R10: Reset is synchronous and active low. While reset is applied, `done_o` is 0 and `result_o` is 0, and any request in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled with the strengths |
| strengths_i | input | 72 | Nine packed unsigned 8-bit set strengths, set 0 in the low byte |
| result_o | output | 9 | Signed crisp increment with 4 fractional bits |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Two functions can fall on the same clock edge. One is publishing the result of a finished division. The other is accepting the next request, whether that request needs a division or takes the zero-sum path. The bench provokes this by raising start exactly on the 21st edge after an accepted request. It also raises start one edge earlier and well inside the division, where the request must be ignored. A monitor records every done pulse with its cycle number and result value. Each scenario is judged by comparing that list against the pulses and values expected from the requirements.

// File: rtl/defz_pkg.sv
// Package: width helpers and divider state type for the defuzzifier.
// Assumes centres are evenly spaced by a step and symmetric about zero.
package defz_pkg;

    // Largest centre magnitude for a symmetric set of singletons
    function automatic int max_centre(input int nsets, input int step);
        return ((nsets - 1) / 2) * step;
    endfunction

    // Bits needed for the magnitude of the weighted sum
    function automatic int num_mag_w(input int nsets, input int str_w, input int step);
        return $clog2(nsets * ((1 << str_w) - 1) * max_centre(nsets, step) + 1);
    endfunction

    // Bits needed for the unsigned strength sum
    function automatic int den_w(input int nsets, input int str_w);
        return $clog2(nsets * ((1 << str_w) - 1) + 1);
    endfunction

    // Signed result width: integer part up to max centre, plus fraction and sign
    function automatic int res_w(input int nsets, input int step, input int frac);
        return $clog2(max_centre(nsets, step) + 1) + frac + 1;
    endfunction

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/defz_wsum.sv
// Weighted sum: multiplies each strength by its constant centre and adds them;
// also sums the raw strengths. Purely combinational.
// Assumes NUM_W and DEN_W are large enough for the worst case (set by the top).
module defz_wsum #(
    parameter int STR_W = 8,
    parameter int NSETS = 9,
    parameter int STEP  = 2,
    parameter int NUM_W = 16,
    parameter int DEN_W = 12
) (
    input  logic [NSETS*STR_W-1:0] strengths_i,
    output logic signed [NUM_W-1:0] num_o,
    output logic [DEN_W-1:0]        den_o
);

    logic signed [NUM_W-1:0] term [NSETS];

    // One constant multiplier per set; the centre is fixed at elaboration
    for (genvar k = 0; k < NSETS; k++) begin : g_term
        localparam int CENTRE = (k - (NSETS - 1) / 2) * STEP;
        assign term[k] = $signed({{(NUM_W-STR_W){1'b0}}, strengths_i[k*STR_W +: STR_W]})
                         * NUM_W'(CENTRE);
    end

    // Adder trees for the numerator and the denominator
    always_comb begin
        num_o = '0;
        den_o = '0;
        for (int k = 0; k < NSETS; k++) begin
            num_o = num_o + term[k];
            den_o = den_o + DEN_W'(strengths_i[k*STR_W +: STR_W]);
        end
    end

endmodule

// File: rtl/defz_rdiv.sv
// Restoring divider: unsigned, one quotient bit per clock, DVD_W clocks per
// division. valid_o pulses on the edge that completes the last bit.
// Assumes divisor_i is nonzero whenever start_i is raised while idle.
module defz_rdiv #(
    parameter int DVD_W = 20,
    parameter int DVS_W = 12,
    parameter int QUO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [QUO_W-1:0] quot_o
);
    import defz_pkg::*;

    localparam int CNT_W = $clog2(DVD_W + 1);
    localparam int REM_W = DVS_W + 1;

    div_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [REM_W-1:0]  rem_q;
    logic [DVD_W-1:0]  quo_q;
    logic [DVS_W-1:0]  dvs_q;
    logic [REM_W-1:0]  shifted;
    logic [REM_W-1:0]  trial;

    // Shift in the next dividend bit and try subtracting the divisor
    always_comb begin
        shifted = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    // Sequencer: load on start, then one restoring step per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
            cnt_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                DIV_IDLE: begin
                    if (start_i) begin
                        rem_q   <= '0;
                        quo_q   <= dividend_i;
                        dvs_q   <= divisor_i;
                        cnt_q   <= CNT_W'(DVD_W);
                        state_q <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    if (!trial[REM_W-1]) begin
                        rem_q <= trial;
                        quo_q <= {quo_q[DVD_W-2:0], 1'b1};
                    end else begin
                        rem_q <= shifted;
                        quo_q <= {quo_q[DVD_W-2:0], 1'b0};
                    end
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_q <= DIV_IDLE;
                        valid_o <= 1'b1;
                    end
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == DIV_RUN);
    assign quot_o = quo_q[QUO_W-1:0];

endmodule

// File: rtl/defz_wavg.sv
// Top: weighted-average defuzzifier. Forms the weighted and plain sums,
// divides the magnitude with FRAC fractional bits, restores the sign and
// publishes the result with a one-cycle done strobe.
// Assumes starts that arrive while the divider runs may be dropped.
module defz_wavg #(
    parameter int STR_W = 8,
    parameter int NSETS = 9,
    parameter int STEP  = 2,
    parameter int FRAC  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NSETS*STR_W-1:0]   strengths_i,
    output logic signed [defz_pkg::res_w(NSETS, STEP, FRAC)-1:0] result_o,
    output logic                     done_o
);

    localparam int NUM_W = defz_pkg::num_mag_w(NSETS, STR_W, STEP) + 1;
    localparam int DEN_W = defz_pkg::den_w(NSETS, STR_W);
    localparam int RES_W = defz_pkg::res_w(NSETS, STEP, FRAC);
    localparam int DVD_W = NUM_W + FRAC;

    logic signed [NUM_W-1:0] num;
    logic [DEN_W-1:0]        den;
    logic [NUM_W-1:0]        num_abs;
    logic [DVD_W-1:0]        dividend;
    logic                    accept;
    logic                    den_zero;
    logic                    div_start;
    logic                    div_busy;
    logic                    div_valid;
    logic [RES_W-2:0]        div_quot;
    logic                    neg_q;
    logic                    zero_pend_q;

    defz_wsum #(
        .STR_W(STR_W), .NSETS(NSETS), .STEP(STEP),
        .NUM_W(NUM_W), .DEN_W(DEN_W)
    ) u_wsum (
        .strengths_i(strengths_i),
        .num_o      (num),
        .den_o      (den)
    );

    // Request decode: magnitude with fraction bits appended, zero-sum bypass
    always_comb begin
        num_abs   = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
        dividend  = {num_abs, {FRAC{1'b0}}};
        accept    = start_i && !div_busy;
        den_zero  = (den == '0);
        div_start = accept && !den_zero;
    end

    defz_rdiv #(
        .DVD_W(DVD_W), .DVS_W(DEN_W), .QUO_W(RES_W-1)
    ) u_rdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .dividend_i(dividend),
        .divisor_i (den),
        .busy_o    (div_busy),
        .valid_o   (div_valid),
        .quot_o    (div_quot)
    );

    // Output stage: latch sign at accept, publish signed quotient or zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q       <= 1'b0;
            zero_pend_q <= 1'b0;
            result_o    <= '0;
            done_o      <= 1'b0;
        end else begin
            done_o      <= 1'b0;
            zero_pend_q <= accept && den_zero;
            if (div_start) begin
                neg_q <= num[NUM_W-1];
            end
            if (div_valid) begin
                result_o <= neg_q ? -$signed({1'b0, div_quot}) : $signed({1'b0, div_quot});
                done_o   <= 1'b1;
            end else if (zero_pend_q) begin
                result_o <= '0;
                done_o   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/defz_wavg_chk.sv
// Checker: temporal properties of the defuzzifier ports and divider status.
// Assumes it is bound into defz_wavg, where div_busy is the divider status.
module defz_wavg_chk #(
    parameter int STR_W = 8,
    parameter int NSETS = 9,
    parameter int STEP  = 2,
    parameter int FRAC  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic [NSETS*STR_W-1:0] strengths_i,
    input logic signed [defz_pkg::res_w(NSETS, STEP, FRAC)-1:0] result_o,
    input logic                   done_o,
    input logic                   div_busy
);

    localparam int MAX_RES = defz_pkg::max_centre(NSETS, STEP) << FRAC;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!done_o && result_o == '0)); // R10

    AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o <= MAX_RES && result_o >= -MAX_RES)); // R4

    AST_ZERO_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !div_busy && strengths_i == '0) |=> ##1 (done_o && result_o == '0)); // R5

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !div_busy && strengths_i != '0) |=> div_busy); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R7

endmodule

bind defz_wavg defz_wavg_chk #(
    .STR_W(STR_W), .NSETS(NSETS), .STEP(STEP), .FRAC(FRAC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .strengths_i(strengths_i),
    .result_o   (result_o),
    .done_o     (done_o),
    .div_busy   (div_busy)
);

// File: tb/tb_defz_wavg.sv
module tb_defz_wavg;

    localparam int LAT_DIV  = 21;
    localparam int LAT_ZERO = 1;
    localparam int NVEC     = 12;

    localparam logic [71:0] VEC [NVEC] = '{
        72'hFF_00_00_00_00_00_00_00_00,
        72'h00_00_00_00_00_00_00_00_FF,
        72'h00_00_00_00_64_00_00_00_00,
        72'h00_00_00_00_64_64_00_00_00,
        72'h00_00_00_01_02_00_00_00_00,
        72'h00_00_00_00_02_01_00_00_00,
        72'hFF_FF_FF_FF_FF_FF_FF_FF_FF,
        72'h00_1E_0A_00_00_00_00_00_00,
        72'h03_00_00_00_00_00_00_00_01,
        72'h00_00_03_00_00_00_00_07_00,
        72'h00_01_00_00_00_00_FF_00_00,
        72'h00_00_00_00_00_00_00_00_00
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [71:0]       strengths = '0;
    logic signed [8:0] result;
    logic              done;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int ev_n = 0;
    int ev_cyc [8];
    int ev_res [8];

    defz_wavg dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .strengths_i(strengths),
        .result_o   (result),
        .done_o     (done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc++;

    // Record every done pulse with its edge number and value
    always @(negedge clk) begin
        if (done && ev_n < 8) begin
            ev_cyc[ev_n] = cyc;
            ev_res[ev_n] = int'(result);
            ev_n++;
        end
    end

    function automatic int exp_res(input logic [71:0] s);
        int num = 0;
        int den = 0;
        for (int k = 0; k < 9; k++) begin
            num += int'(s[k*8 +: 8]) * (2*k - 8);
            den += int'(s[k*8 +: 8]);
        end
        if (den == 0) return 0;
        return (num * 16) / den;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; start is sampled on the following posedge
    task automatic drive_start(input logic [71:0] s);
        strengths = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Request A, then poke B so it is sampled on edge pe after A's accept
    task automatic poke_run(input logic [71:0] a, input logic [71:0] b,
                            input int pe, output int c0);
        ev_n = 0;
        drive_start(a);
        c0 = cyc;
        repeat (pe - 1) @(negedge clk);
        drive_start(b);
        repeat (60) @(negedge clk);
    endtask

    task automatic single(input logic [71:0] s, input string tag);
        int c0;
        int e;
        ev_n = 0;
        drive_start(s);
        c0 = cyc;
        repeat (30) @(negedge clk);
        e = exp_res(s);
        chk(ev_n == 1, {tag, " one done"}, ev_n, 1);
        chk(ev_res[0] == e, tag, ev_res[0], e);
    endtask

    initial begin
        int c0;
        int e;
        int ea;
        int eb;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R10 reset done", int'(done), 0);
        chk(result == 0, "R10 reset result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: value, latency, one pulse, hold, range
        for (int i = 0; i < NVEC; i++) begin
            bit zero;
            zero = (VEC[i] == '0);
            e = exp_res(VEC[i]);
            ev_n = 0;
            drive_start(VEC[i]);
            c0 = cyc;
            repeat (30) @(negedge clk);
            chk(ev_n == 1, "R7 one done per request", ev_n, 1);
            chk(ev_res[0] == e, (e < 0) ? "R3 signed value" : "R2 value", ev_res[0], e);
            if (zero)
                chk(ev_cyc[0] - c0 == LAT_ZERO, "R5 zero-sum latency", ev_cyc[0] - c0, LAT_ZERO);
            else
                chk(ev_cyc[0] - c0 == LAT_DIV, "R6 division latency", ev_cyc[0] - c0, LAT_DIV);
            chk(ev_res[0] <= 128 && ev_res[0] >= -128, "R4 range", ev_res[0], 128);
            chk(int'(result) == e, "R7 result held", int'(result), e);
        end

        // R1: single sets checked against their centres
        single(72'h00_00_00_32_00_00_00_00_00, "R1 set5 centre +2");
        single(72'h00_00_00_00_00_00_09_00_00, "R1 set2 centre -4");
        single(72'h00_00_00_00_00_00_00_01_00, "R1 set1 centre -6");

        // R8: starts inside the division are ignored
        ea = exp_res(VEC[7]);
        poke_run(VEC[7], VEC[1], 5, c0);
        chk(ev_n == 1, "R8 poke edge 5 extra done", ev_n, 1);
        chk(ev_res[0] == ea, "R8 poke edge 5 value", ev_res[0], ea);
        chk(ev_cyc[0] - c0 == LAT_DIV, "R8 poke edge 5 timing", ev_cyc[0] - c0, LAT_DIV);
        poke_run(VEC[7], VEC[1], LAT_DIV - 1, c0);
        chk(ev_n == 1, "R8 poke edge 20 extra done", ev_n, 1);
        chk(ev_res[0] == ea, "R8 poke edge 20 value", ev_res[0], ea);

        // R9: start on the publishing edge is accepted
        eb = exp_res(VEC[1]);
        poke_run(VEC[7], VEC[1], LAT_DIV, c0);
        chk(ev_n == 2, "R9 two dones", ev_n, 2);
        chk(ev_res[0] == ea && ev_cyc[0] - c0 == LAT_DIV, "R9 first result", ev_res[0], ea);
        chk(ev_res[1] == eb, "R9 second value", ev_res[1], eb);
        chk(ev_cyc[1] - c0 == 2*LAT_DIV, "R9 second timing", ev_cyc[1] - c0, 2*LAT_DIV);
        poke_run(VEC[7], '0, LAT_DIV, c0);
        chk(ev_n == 2, "R9 zero follow-up dones", ev_n, 2);
        chk(ev_res[1] == 0 && ev_cyc[1] - c0 == LAT_DIV + 1, "R9 zero follow-up",
            ev_cyc[1] - c0, LAT_DIV + 1);

        // R10: reset during a division drops it
        ev_n = 0;
        drive_start(VEC[0]);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && result == 0, "R10 mid-run reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(ev_n == 0, "R10 dropped request", ev_n, 0);
        single(VEC[3], "R10 request after reset");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule